// File: doc/BRIEF.md
# Atomic 16-bit register byte access

This block lets an 8-bit bus reach a set of 16-bit registers without tearing. One temporary byte, shared by every register behind the bridge, holds a high byte between two byte accesses. A read of a low byte returns that byte from the live register at once and copies the register's live high byte into the temporary byte in the same clock. A later read of the high byte address returns the copy, so the two bytes belong to the same instant. Software therefore reads low first, then high.

Writes run the other way round. A high-byte write only fills the temporary byte. The following low-byte write issues a one-cycle load strobe to the selected register, with the 16-bit value formed from the temporary byte and the bus byte. Software therefore writes high first, then low. The registers themselves live outside the bridge. Their live values come in on a flat bus, and the bridge sends back a per-register load strobe and one shared 16-bit load value.

Bit 0 of the byte address selects the byte: 0 is the low byte and 1 is the high byte. The bits above bit 0 select the register index.

Top module: `wide16_bridge`

## Requirements
- R1: After reset the temporary byte is 0x00, so a high-byte read issued before any low-byte read returns 0x00.
- R2: While the address selects the low byte (bit 0 = 0) of an existing register, the read data equals that register's live low byte in the same cycle.
- R3: A read of a low byte with no write in the same cycle copies the register's live high byte, as it stood before that clock edge, into the temporary byte. Later high-byte reads return that copy even if the register has changed since.
- R4: While the address selects a high byte (bit 0 = 1) of an existing register, the read data is the temporary byte. A high-byte read leaves the temporary byte unchanged.
- R5: A high-byte write stores the bus byte in the temporary byte and raises no load strobe, so the register keeps its value.
- R6: A low-byte write raises the load strobe of the selected register only, for that one cycle. The load value has the temporary byte in bits 15:8 and the bus byte in bits 7:0.
- R7: The temporary byte is shared by all registers. A high-byte read returns the copy left by the last low-byte read of any register, and a low-byte write commits the high byte staged by a high-byte write to any register.
- R8: A register index at or above NREG returns read data 0x00, raises no load strobe and leaves the temporary byte unchanged, for reads and writes alike.
- R9: When read and write are both asserted, the write is performed and the read makes no copy into the temporary byte.
- R10: A low-byte write leaves the temporary byte unchanged, so successive low-byte writes reuse the same staged high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read request for this cycle |
| bus_wr | input | 1 | Write request for this cycle |
| bus_addr | input | AW | Bit 0 selects the byte (0 low, 1 high); the upper bits select the register index |
| bus_wdata | input | 8 | Write byte |
| reg_value_i | input | NREG*16 | Live register values; register i is in bits [16i+15:16i] |
| bus_rdata | output | 8 | Read byte (combinational) |
| reg_load_o | output | NREG | One-cycle load strobe for each register |
| reg_wdata_o | output | 16 | Value to load: {temporary byte, bus_wdata} |

## Verification
Two things can fall in the same cycle. A low-byte read can coincide with a change of the live register, and a read request can coincide with a write request. The bench provokes the first by updating the register model at the same clock edge that ends a low-byte read. It judges the result by checking that the read returned the old low byte and that the following high-byte read returns the old high byte, not the new one. For the second, the bench stages a high byte, then issues a combined read and write to a low byte whose live high byte differs. The write must commit the staged value, and the next high-byte read must show the staged byte rather than a fresh copy.

// File: rtl/wide16_bridge.sv
module wide16_bridge #(
  parameter int NREG = 3,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int AW = IW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic [NREG*16-1:0] reg_value_i,
  output logic [7:0]        bus_rdata,
  output logic [NREG-1:0]   reg_load_o,
  output logic [15:0]       reg_wdata_o
);
  logic [IW-1:0] sel;
  logic          hi_sel;
  logic          in_range;
  logic [15:0]   live;
  logic [7:0]    temp_q;

  assign sel      = bus_addr[AW-1:1];
  assign hi_sel   = bus_addr[0];
  assign in_range = 32'(sel) < NREG;

  always_comb begin
    live = '0;
    for (int i = 0; i < NREG; i++)
      if (sel == IW'(i)) live = reg_value_i[i*16 +: 16];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      temp_q <= '0;
    else if (in_range) begin
      if (bus_wr && hi_sel)
        temp_q <= bus_wdata;
      else if (bus_rd && !bus_wr && !hi_sel)
        temp_q <= live[15:8];
    end
  end

  assign bus_rdata   = !in_range ? 8'h00 : (hi_sel ? temp_q : live[7:0]);
  assign reg_wdata_o = {temp_q, bus_wdata};

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_load
      assign reg_load_o[g] = bus_wr && !hi_sel && (sel == IW'(g));
    end
  endgenerate
endmodule

// File: rtl/wide16_bridge_chk.sv
module wide16_bridge_chk #(
  parameter int NREG = 3,
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int AW = IW + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [AW-1:0]     bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [NREG*16-1:0] reg_value_i,
  input logic [7:0]        bus_rdata,
  input logic [NREG-1:0]   reg_load_o,
  input logic [15:0]       reg_wdata_o
);
  logic [IW-1:0] c_idx;
  logic          c_ok;
  logic [7:0]    c_live_hi;
  logic          c_lo_read;
  logic          c_hi_read;

  assign c_idx = bus_addr[AW-1:1];
  assign c_ok  = 32'(c_idx) < NREG;
  assign c_lo_read = bus_rd && !bus_wr && !bus_addr[0] && c_ok;
  assign c_hi_read = bus_rd && !bus_wr && bus_addr[0] && c_ok;

  always_comb begin
    c_live_hi = '0;
    for (int k = 0; k < NREG; k++)
      if (32'(c_idx) == k) c_live_hi = reg_value_i[k*16+8 +: 8];
  end

  a_r3_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    c_lo_read ##1 c_hi_read |-> bus_rdata == $past(c_live_hi));

  a_r4_hi_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
    c_hi_read ##1 c_hi_read |-> $stable(bus_rdata));

  a_r5_hi_write_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[0]) |-> reg_load_o == '0);

  a_r6_load_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_load_o));

  a_r6_load_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_load_o != '0) |-> reg_wdata_o[7:0] == bus_wdata);

  a_r6_load_present: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr[0] && c_ok) |-> $countones(reg_load_o) == 1);

  a_r5_staged_high: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[0] && c_ok) |=> reg_wdata_o[15:8] == $past(bus_wdata));

  a_r8_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    !c_ok |-> (reg_load_o == '0 && bus_rdata == 8'h00));
endmodule

bind wide16_bridge wide16_bridge_chk #(.NREG(NREG)) u_chk (.*);

// File: tb/wide16_bridge_bench.sv
`timescale 1ns/1ps
module wide16_bridge_bench;
  localparam int NREG = 3;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [NREG*16-1:0] reg_value_i;
  logic [7:0] bus_rdata;
  logic [NREG-1:0] reg_load_o;
  logic [15:0] reg_wdata_o;

  logic [15:0] live [NREG];
  logic frc_en = 1'b0;
  int   frc_idx = 0;
  logic [15:0] frc_val = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wide16_bridge #(.NREG(NREG)) u_wide16_bridge (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .reg_value_i(reg_value_i),
    .bus_rdata(bus_rdata), .reg_load_o(reg_load_o), .reg_wdata_o(reg_wdata_o));

  assign reg_value_i = {live[2], live[1], live[0]};

  always @(posedge clk) begin
    if (!rst_n) begin
      live[0] <= 16'h1234;
      live[1] <= 16'hABCD;
      live[2] <= 16'h5A0F;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (reg_load_o[i]) live[i] <= reg_wdata_o;
      if (frc_en) live[frc_idx] <= frc_val;
    end
  end

  // {write, addr, wdata, expected rdata, expected load mask, expected load value}
  localparam int NV = 17;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0, 3'd1, 8'h00, 8'h00, 3'b000, 16'h0000},
    {1'b0, 3'd0, 8'h00, 8'h34, 3'b000, 16'h0000},
    {1'b0, 3'd1, 8'h00, 8'h12, 3'b000, 16'h0000},
    {1'b0, 3'd2, 8'h00, 8'hCD, 3'b000, 16'h0000},
    {1'b0, 3'd1, 8'h00, 8'hAB, 3'b000, 16'h0000},
    {1'b1, 3'd3, 8'h77, 8'h00, 3'b000, 16'h0000},
    {1'b0, 3'd3, 8'h00, 8'h77, 3'b000, 16'h0000},
    {1'b0, 3'd2, 8'h00, 8'hCD, 3'b000, 16'h0000},
    {1'b1, 3'd5, 8'h99, 8'h00, 3'b000, 16'h0000},
    {1'b1, 3'd4, 8'h11, 8'h00, 3'b100, 16'h9911},
    {1'b1, 3'd0, 8'h22, 8'h00, 3'b001, 16'h9922},
    {1'b0, 3'd4, 8'h00, 8'h11, 3'b000, 16'h0000},
    {1'b0, 3'd0, 8'h00, 8'h22, 3'b000, 16'h0000},
    {1'b0, 3'd6, 8'h00, 8'h00, 3'b000, 16'h0000},
    {1'b1, 3'd7, 8'h55, 8'h00, 3'b000, 16'h0000},
    {1'b0, 3'd1, 8'h00, 8'h99, 3'b000, 16'h0000},
    {1'b1, 3'd6, 8'h44, 8'h00, 3'b000, 16'h0000}
  };

  logic [7:0] got_rd;
  logic [NREG-1:0] got_ld;
  logic [15:0] got_lv;

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic acc(input logic rd, input logic wr, input logic [AW-1:0] a,
                     input logic [7:0] wd, input logic fe = 1'b0,
                     input int fi = 0, input logic [15:0] fv = '0);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    frc_en = fe; frc_idx = fi; frc_val = fv;
    #1;
    got_rd = bus_rdata; got_ld = reg_load_o; got_lv = reg_wdata_o;
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; frc_en = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [38:0] e;
      e = VEC[v];
      acc(!e[38], e[38], e[37:35], e[34:27]);
      if (!e[38]) begin
        check($sformatf("R1 R2 R3 R4 R7 R8 vec%0d rdata", v), 16'(got_rd), 16'(e[26:19]));
        check($sformatf("R4 vec%0d no load on read", v), 16'(got_ld), 16'h0);
      end else begin
        check($sformatf("R5 R6 R8 vec%0d load mask", v), 16'(got_ld), 16'(e[18:16]));
        if (e[18:16] != 0)
          check($sformatf("R6 R10 vec%0d load value", v), got_lv, e[15:0]);
      end
    end

    // R3: register changes between low and high reads
    acc(1, 0, 3'd2, 8'h00);
    check("R2 low r1", 16'(got_rd), 16'h00CD);
    idle();
    acc(0, 0, 3'd0, 8'h00, 1'b1, 1, 16'hFEED);
    acc(1, 0, 3'd3, 8'h00);
    check("R3 snapshot survives change", 16'(got_rd), 16'h00AB);
    acc(1, 0, 3'd2, 8'h00);
    check("R2 new low byte", 16'(got_rd), 16'h00ED);

    // R3: change at the same edge as the low read
    acc(1, 0, 3'd4, 8'h00, 1'b1, 2, 16'hCDEF);
    check("R3 same-edge low read old value", 16'(got_rd), 16'h0011);
    acc(1, 0, 3'd5, 8'h00);
    check("R3 same-edge copy is old high", 16'(got_rd), 16'h0099);
    acc(1, 0, 3'd4, 8'h00);
    check("R2 low after change", 16'(got_rd), 16'h00EF);

    // R9: read and write together
    acc(0, 1, 3'd1, 8'h3C);
    acc(1, 1, 3'd0, 8'h5E);
    check("R9 load mask", 16'(got_ld), 16'h0001);
    check("R9 load value", got_lv, 16'h3C5E);
    acc(1, 0, 3'd1, 8'h00);
    check("R9 no copy on combined access", 16'(got_rd), 16'h003C);

    // R7: stage via one register, commit to another
    acc(0, 1, 3'd5, 8'h66);
    acc(0, 1, 3'd2, 8'h01);
    check("R7 cross-register load mask", 16'(got_ld), 16'h0002);
    check("R7 cross-register load value", got_lv, 16'h6601);
    acc(1, 0, 3'd2, 8'h00);
    check("R6 register took low byte", 16'(got_rd), 16'h0001);
    acc(1, 0, 3'd3, 8'h00);
    check("R6 register took staged high", 16'(got_rd), 16'h0066);
    idle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule